// File: doc/BRIEF.md
# DRAM Periodic Refresh Controller

This block keeps the contents of a DRAM array alive by scheduling row refreshes so that each of the `ROWS` rows is restored within the retention time. An interval timer produces one refresh obligation every `TICK_CYC` clock cycles. These obligations collect in a pending counter. A small sequencer turns each obligation into one refresh command to the array, and it shares the array with normal traffic through a request/grant pair. Every row refresh holds the array for `RC_CYC` cycles of row activation. During that time `ref_busy` is high and no access is granted.

Two choices are made at run time. `burst_mode` selects how obligations are produced. With it low they are spread out, one per interval. With it high the controller waits a full period of `ROWS` intervals and then owes all rows at once, and those rows are refreshed back to back. `cbr_mode` selects the command form. With it low the controller drives the row address itself and pulses only the row strobe. With it high the column strobe goes active first and the DRAM's internal row counter picks the row. The controller keeps its own row counter in both forms. It also counts completed refreshes and busy cycles, so the unavailable fraction of time equals `busy_cycles` divided by elapsed cycles.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `ras_n` and `cas_n` are 1, `acc_gnt` and `ref_busy` are 0, and `ref_count`, `busy_cycles` and `row_addr` are 0.
- R2: With `burst_mode` = 0, one refresh obligation is added every `TICK_CYC` cycles. The first is added `TICK_CYC` cycles after reset is released. With no competing traffic, each refresh completes within `RC_CYC`+2 cycles of its obligation.
- R3: With `burst_mode` = 1, `ROWS` obligations are added together once every `ROWS`×`TICK_CYC` cycles. Idle traffic then sees the rows refreshed back to back, with one idle precharge cycle after each row, so a RAS-only burst ends `ROWS`×(`RC_CYC`+1) cycles after it is owed.
- R4: A RAS-only refresh (`cbr_mode` = 0) holds `ras_n` at 0 for exactly `RC_CYC` consecutive cycles. During those cycles `cas_n` is 1 and `row_addr` carries the controller's current row.
- R5: A CAS-before-RAS refresh (`cbr_mode` = 1) drives `cas_n` to 0 for one cycle while `ras_n` is 1. It then holds both at 0 for `RC_CYC` cycles, with `row_addr` at 0.
- R6: The row counter starts at 0, advances by one with each completed refresh, and wraps from `ROWS`-1 to 0.
- R7: Once `acc_gnt` is high it stays high for as long as `acc_req` stays high. While `acc_gnt` is high, `ras_n` is 1 and `ref_busy` is 0, so a refresh that falls due waits for the access to end.
- R8: When idle, a new access request is granted ahead of the refresh only while the pending count is at most `OVERDUE_LIM`. Above that, refreshes run first until the count falls back to `OVERDUE_LIM`.
- R9: The pending count saturates at 2×`ROWS`. Obligations that arrive while it is full are dropped.
- R10: `ref_count` equals the number of completed refreshes. `busy_cycles` equals the number of cycles in which `ref_busy` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode | input | 1 | 1: refresh all rows once per period; 0: one row per interval |
| cbr_mode | input | 1 | 1: CAS-before-RAS command form; 0: RAS-only with row address |
| acc_req | input | 1 | Normal access wants the array; held high for the whole access |
| acc_gnt | output | 1 | Normal access owns the array |
| ref_busy | output | 1 | Refresh in progress, array unavailable |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_W | Row being refreshed in RAS-only form, else 0 |
| ref_count | output | CNT_W | Completed refreshes |
| busy_cycles | output | CNT_W | Cycles spent with ref_busy high |

## Verification
On every cycle, the embedded assertions check the following: the column strobe leads the row strobe in CAS-before-RAS form, a grant is held while its request stays high, an overdue idle controller gives no fresh grant, the interval timer reloads after each tick, the row counter wraps, the pending count stays within its bound, and the busy-cycle counter steps with `ref_busy`. Some behaviours depend on whole traffic histories, and only the bench scenarios show them. These are the interval spacing and burst timing measured in cycles, the exact number of refreshes run before a held-off access is granted again, the loss of obligations once the pending count saturates, and the bound on how far refresh lags behind under random access traffic.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_CBR  = 2'd2,
    ST_ACT  = 2'd3
  } ref_state_t;
endpackage

// File: rtl/ref_timer.sv
module ref_timer #(
  parameter int TICK_CYC = 781,
  parameter int ROWS     = 4096
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o,
  output logic period_o
);
  localparam int TICK_W = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
  localparam int ROW_W  = (ROWS > 2) ? $clog2(ROWS) : 1;

  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0]  per_q, per_d;

  always_comb begin
    tick_o   = (cnt_q == '0);
    period_o = tick_o && (per_q == ROW_W'(ROWS-1));
    cnt_d    = tick_o ? TICK_W'(TICK_CYC-1) : cnt_q - 1'b1;
    per_d    = per_q;
    if (tick_o) per_d = period_o ? '0 : per_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= TICK_W'(TICK_CYC-1);
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  // R2: interval timer restarts a full interval after each tick
  a_r2_tick_reload: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == TICK_W'(TICK_CYC-1)));
endmodule

// File: rtl/ref_tracker.sv
module ref_tracker #(
  parameter int ROWS        = 4096,
  parameter int OVERDUE_LIM = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  period_i,
  input  logic                  burst_i,
  input  logic                  done_i,
  output logic                  pend_nz_o,
  output logic                  urgent_o,
  output logic [((ROWS > 2) ? $clog2(ROWS) : 1)-1:0] row_o
);
  localparam int ROW_W    = (ROWS > 2) ? $clog2(ROWS) : 1;
  localparam int PEND_MAX = 2 * ROWS;
  localparam int PEND_W   = $clog2(PEND_MAX + 1);
  localparam int PW1      = PEND_W + 1;

  logic [PEND_W-1:0] pend_q, pend_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [PW1-1:0]    add_w, sum_w;

  always_comb begin
    if (burst_i) add_w = period_i ? PW1'(ROWS) : '0;
    else         add_w = {{PEND_W{1'b0}}, tick_i};
    sum_w  = {1'b0, pend_q} + add_w - {{PEND_W{1'b0}}, done_i};
    pend_d = (sum_w > PW1'(PEND_MAX)) ? PEND_W'(PEND_MAX) : sum_w[PEND_W-1:0];
    row_d  = row_q;
    if (done_i) row_d = (row_q == ROW_W'(ROWS-1)) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      row_q  <= '0;
    end else begin
      pend_q <= pend_d;
      row_q  <= row_d;
    end
  end

  assign pend_nz_o = (pend_q != '0);
  assign urgent_o  = (pend_q > PEND_W'(OVERDUE_LIM));
  assign row_o     = row_q;

  // R6: last row is followed by row 0
  a_r6_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && row_q == ROW_W'(ROWS-1)) |=> (row_q == '0));
  // R9: pending obligations never exceed the cap
  a_r9_pend_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PEND_W'(PEND_MAX));
endmodule

// File: rtl/ref_seq.sv
module ref_seq
  import dref_pkg::*;
#(
  parameter int RC_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req_i,
  input  logic pend_nz_i,
  input  logic urgent_i,
  input  logic cbr_i,
  output logic acc_gnt_o,
  output logic busy_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic drive_row_o,
  output logic done_o
);
  localparam int RC_W = (RC_CYC > 2) ? $clog2(RC_CYC) : 1;

  ref_state_t      state_q, state_d;
  logic [RC_W-1:0] rc_q, rc_d;
  logic            cbr_q, cbr_d;

  always_comb begin
    state_d = state_q;
    rc_d    = rc_q;
    cbr_d   = cbr_q;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (acc_req_i && !urgent_i) begin
          state_d = ST_ACC;
        end else if (pend_nz_i) begin
          cbr_d   = cbr_i;
          rc_d    = '0;
          state_d = cbr_i ? ST_CBR : ST_ACT;
        end
      end
      ST_ACC:  if (!acc_req_i) state_d = ST_IDLE;
      ST_CBR:  state_d = ST_ACT;
      ST_ACT: begin
        if (rc_q == RC_W'(RC_CYC-1)) begin
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          rc_d = rc_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rc_q    <= '0;
      cbr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rc_q    <= rc_d;
      cbr_q   <= cbr_d;
    end
  end

  assign acc_gnt_o   = (state_q == ST_ACC);
  assign busy_o      = (state_q == ST_CBR) || (state_q == ST_ACT);
  assign ras_n_o     = !(state_q == ST_ACT);
  assign cas_n_o     = !((state_q == ST_CBR) || (state_q == ST_ACT && cbr_q));
  assign drive_row_o = (state_q == ST_ACT) && !cbr_q;

  // R5: column strobe already active when the row strobe falls
  a_r5_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n_o) && cbr_q) |-> $past(!cas_n_o));
  // R7: a granted access keeps the array while it requests
  a_r7_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_gnt_o && acc_req_i) |=> acc_gnt_o);
  // R8: overdue refresh blocks a fresh grant
  a_r8_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && urgent_i) |=> !acc_gnt_o);
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ROWS        = 4096,
  parameter int TICK_CYC    = 781,
  parameter int RC_CYC      = 5,
  parameter int OVERDUE_LIM = 4,
  parameter int CNT_W       = 24,
  localparam int ROW_W      = (ROWS > 2) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_mode,
  input  logic             cbr_mode,
  input  logic             acc_req,
  output logic             acc_gnt,
  output logic             ref_busy,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row_addr,
  output logic [CNT_W-1:0] ref_count,
  output logic [CNT_W-1:0] busy_cycles
);
  logic tick_w, period_w, done_w, pend_nz_w, urgent_w, drive_row_w;
  logic [ROW_W-1:0] row_w;
  logic [CNT_W-1:0] ref_cnt_q, ref_cnt_d, busy_q, busy_d;

  ref_timer #(.TICK_CYC(TICK_CYC), .ROWS(ROWS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_w), .period_o(period_w)
  );

  ref_tracker #(.ROWS(ROWS), .OVERDUE_LIM(OVERDUE_LIM)) u_tracker (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .period_i(period_w),
    .burst_i(burst_mode), .done_i(done_w), .pend_nz_o(pend_nz_w),
    .urgent_o(urgent_w), .row_o(row_w)
  );

  ref_seq #(.RC_CYC(RC_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc_req_i(acc_req), .pend_nz_i(pend_nz_w),
    .urgent_i(urgent_w), .cbr_i(cbr_mode), .acc_gnt_o(acc_gnt),
    .busy_o(ref_busy), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .drive_row_o(drive_row_w), .done_o(done_w)
  );

  always_comb begin
    ref_cnt_d = done_w   ? ref_cnt_q + 1'b1 : ref_cnt_q;
    busy_d    = ref_busy ? busy_q + 1'b1    : busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt_q <= '0;
      busy_q    <= '0;
    end else begin
      ref_cnt_q <= ref_cnt_d;
      busy_q    <= busy_d;
    end
  end

  assign row_addr    = drive_row_w ? row_w : '0;
  assign ref_count   = ref_cnt_q;
  assign busy_cycles = busy_q;

  // R10: busy-cycle counter tracks the busy flag
  a_r10_busy_count: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |=> (busy_cycles == $past(busy_cycles) + 1'b1));
endmodule

// File: tb/test_dram_refresh_ctrl.sv
module test_dram_refresh_ctrl;
  localparam int ROWS = 8;
  localparam int TICK = 25;
  localparam int RC   = 3;
  localparam int OV   = 2;
  localparam int CW   = 24;
  localparam int RW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_mode = 1'b0, cbr_mode = 1'b0, acc_req = 1'b0;
  logic acc_gnt, ref_busy, ras_n, cas_n;
  logic [RW-1:0] row_addr;
  logic [CW-1:0] ref_count, busy_cycles;

  always #10 clk = ~clk;

  dram_refresh_ctrl #(.ROWS(ROWS), .TICK_CYC(TICK), .RC_CYC(RC),
    .OVERDUE_LIM(OV), .CNT_W(CW)) i_dram_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .cbr_mode(cbr_mode),
    .acc_req(acc_req), .acc_gnt(acc_gnt), .ref_busy(ref_busy), .ras_n(ras_n),
    .cas_n(cas_n), .row_addr(row_addr), .ref_count(ref_count),
    .busy_cycles(busy_cycles)
  );

  int cyc;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // expected-value functions
  function automatic int exp_ticks(int c);
    return c / TICK;
  endfunction
  function automatic int exp_burst_end(int periods, bit cbr);
    return periods * ROWS * TICK + ROWS * (RC + (cbr ? 2 : 1));
  endfunction

  // ---------------- per-cycle monitor ----------------
  int  mon_chk, mon_fail;
  bit  lag_en;
  int  run, runs, exp_row, bench_busy;
  logic p_ras_n, p_cas_n, p_gnt, p_req;

  task automatic mchk(input bit ok, input string rq, input longint act, input longint exp);
    mon_chk++;
    if (!ok) begin
      mon_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", rq, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      run = 0; runs = 0; exp_row = 0; bench_busy = 0;
      p_ras_n = 1'b1; p_cas_n = 1'b1; p_gnt = 1'b0; p_req = 1'b0;
    end else begin
      if (acc_gnt) begin
        mchk(ras_n == 1'b1, "R7 no refresh while granted", ras_n, 1);
        mchk(ref_busy == 1'b0, "R7 not busy while granted", ref_busy, 0);
      end
      if (p_gnt && p_req) mchk(acc_gnt == 1'b1, "R7 grant held", acc_gnt, 1);
      if (!ras_n) begin
        if (run == 0 && cbr_mode) begin
          mchk(p_cas_n == 1'b0 && p_ras_n == 1'b1, "R5 cas before ras", p_cas_n, 0);
        end
        if (cbr_mode) begin
          mchk(cas_n == 1'b0, "R5 cas held", cas_n, 0);
          mchk(row_addr == '0, "R5 row addr idle", row_addr, 0);
        end else begin
          mchk(cas_n == 1'b1, "R4 cas inactive", cas_n, 1);
          mchk(row_addr == RW'(exp_row), "R4 R6 row addr", row_addr, exp_row);
        end
        run++;
      end else if (run > 0) begin
        mchk(run == RC, "R4 ras low length", run, RC);
        runs++;
        exp_row = (exp_row + 1) % ROWS;
        mchk(ref_count == CW'(runs), "R10 ref_count", ref_count, runs);
        run = 0;
      end
      if (!ref_busy) mchk(busy_cycles == CW'(bench_busy), "R10 busy_cycles", busy_cycles, bench_busy);
      else bench_busy++;
      if (lag_en) mchk(exp_ticks(cyc) - int'(ref_count) <= OV + 2, "R8 refresh lag bound",
                       exp_ticks(cyc) - int'(ref_count), OV + 2);
      p_ras_n = ras_n; p_cas_n = cas_n; p_gnt = acc_gnt; p_req = acc_req;
    end
  end

  // ---------------- directed / random stimulus ----------------
  int dir_chk, dir_fail;
  bit timeout;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    dir_chk++;
    if (!ok) begin
      dir_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", rq, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic do_reset(input bit bm, input bit cm, input bit req);
    @(negedge clk);
    rst_n = 1'b0; burst_mode = bm; cbr_mode = cm; acc_req = req;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && !acc_gnt && !ref_busy, "R1 strobes idle in reset", {ras_n, cas_n, acc_gnt, ref_busy}, 4'b1100);
    chk(ref_count == '0 && busy_cycles == '0 && row_addr == '0, "R1 counters zero", ref_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && ref_count == '0, "R1 idle after release", {ras_n, cas_n}, 2'b11);
  endtask

  task automatic rand_traffic(input int until_cyc);
    while (cyc < until_cyc) begin
      acc_req = 1'b0;
      repeat ($urandom_range(0, 10)) @(negedge clk);
      acc_req = 1'b1;
      while (!acc_gnt) @(negedge clk);
      repeat ($urandom_range(1, 20) - 1) @(negedge clk);
      acc_req = 1'b0;
      @(negedge clk);
    end
    acc_req = 1'b0;
  endtask

  task automatic run_all();
    // distributed, RAS-only, idle traffic
    do_reset(1'b0, 1'b0, 1'b0);
    for (int m = 0; m <= 12; m++) begin
      wait_cyc(m * TICK + TICK / 2);
      chk(ref_count == CW'(exp_ticks(cyc)), "R2 one refresh per interval", ref_count, exp_ticks(cyc));
    end
    // distributed, CAS-before-RAS
    do_reset(1'b0, 1'b1, 1'b0);
    wait_cyc(10 * TICK + TICK / 2);
    chk(ref_count == 10, "R2 R5 interval refresh cbr", ref_count, 10);
    // bursty, RAS-only
    do_reset(1'b1, 1'b0, 1'b0);
    wait_cyc(ROWS * TICK - 5);
    chk(ref_count == 0, "R3 nothing before period end", ref_count, 0);
    wait_cyc(exp_burst_end(1, 1'b0) - 1);
    chk(ref_count == ROWS - 1, "R3 burst back to back", ref_count, ROWS - 1);
    wait_cyc(exp_burst_end(1, 1'b0));
    chk(ref_count == ROWS, "R3 burst complete", ref_count, ROWS);
    chk(busy_cycles == ROWS * RC, "R3 R10 burst unavailability", busy_cycles, ROWS * RC);
    wait_cyc(exp_burst_end(2, 1'b0) + 3);
    chk(ref_count == 2 * ROWS, "R3 R6 second burst", ref_count, 2 * ROWS);
    // bursty, CAS-before-RAS
    do_reset(1'b1, 1'b1, 1'b0);
    wait_cyc(exp_burst_end(1, 1'b1) + 2);
    chk(ref_count == ROWS, "R3 R5 cbr burst", ref_count, ROWS);
    chk(busy_cycles == ROWS * (RC + 1), "R5 R10 cbr busy per row", busy_cycles, ROWS * (RC + 1));
    // hold-off and overdue priority
    do_reset(1'b0, 1'b0, 1'b1);
    wait_cyc(130);
    chk(acc_gnt == 1'b1 && ref_count == 0, "R7 access holds off refresh", ref_count, 0);
    acc_req = 1'b0;
    @(negedge clk);
    acc_req = 1'b1;
    while (!acc_gnt) @(negedge clk);
    chk(ref_count == 5 - OV, "R8 overdue refreshes first", ref_count, 5 - OV);
    chk(cyc == 144, "R8 regrant cycle", cyc, 144);
    wait_cyc(146);
    acc_req = 1'b0;
    wait_cyc(190);
    chk(ref_count == exp_ticks(190), "R8 backlog drained", ref_count, exp_ticks(190));
    // saturation of pending obligations
    do_reset(1'b0, 1'b0, 1'b1);
    wait_cyc(512);
    acc_req = 1'b0;
    wait_cyc(615);
    chk(ref_count == 2 * ROWS + 4, "R9 pending saturates", ref_count, 2 * ROWS + 4);
    // random traffic, both command forms
    for (int f = 0; f < 2; f++) begin
      do_reset(1'b0, f[0], 1'b0);
      lag_en = 1'b1;
      rand_traffic(2500);
      lag_en = 1'b0;
      wait_cyc(2500 + TICK + 10);
      chk(ref_count == CW'(exp_ticks(cyc)), "R2 R8 random catches up", ref_count, exp_ticks(cyc));
    end
  endtask

  initial begin
    void'($urandom(32'd4100));
    lag_en = 1'b0;
    timeout = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      dir_chk++;
      dir_fail++;
      $display("FAIL watchdog at cycle %0d: actual 1 expected 0", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             dir_chk + mon_chk, dir_fail + mon_fail);
    $finish;
  end
endmodule